// File: doc/BRIEF.md
# Call and Interrupt Stack Controller

This block keeps the return context for subroutine calls and interrupts in a stack held in the first 256-byte bank of data memory. When the core asks for a push, the block takes the program counter and the program status byte. It then writes a four-byte frame over four consecutive cycles through a plain byte-wide RAM port. A pop reads the same frame back in reverse order. The cycle after the last read, it presents the restored program counter and status byte to the core with a one-cycle valid strobe.

The stack pointer is an 8-bit register that software loads and reads as a whole byte. It always holds an even value. A push decrements it before each store and wraps below 0x00 to 0xFF, so loading 0x00 places the first stored byte at 0xFF. Stack traffic uses its own RAM port and is never gated by any data-memory enable. While a frame transfer is in progress, software writes to the pointer are refused and reported on an error strobe. The pointer's reset value is only a convenience, and software is expected to load it before the first call.

Top module: `call_stack_ctrl`

## Requirements
- R1: All stack RAM accesses fall in bank 0. The RAM address bits above bit 7 are zero, and the low 8 bits are the stack location.
- R2: A software write while idle loads `sp_rd` with `{sp_wr_data[7:1], 0}` in the following cycle. Bit 0 of the pointer always reads 0.
- R3: A push accepted from idle drives `busy` and `ram_we` for the next four cycles. It writes addresses sp-1, sp-2, sp-3 and sp-4 (modulo 256) in that order, with the bytes: the PC upper bits (zero-extended to 8 bits), the PC low byte, the status byte, then 0x00. After that the pointer reads sp-4.
- R4: Downward wrap: with the pointer at 0x00, a push writes 0xFF, 0xFE, 0xFD, 0xFC and leaves the pointer at 0xFC.
- R5: A pop accepted from idle holds `busy` for four cycles with `ram_we` low. It reads addresses sp, sp+1, sp+2 and sp+3 (modulo 256), expecting pad, status, PC low and PC high. After that the pointer reads sp+4 (modulo 256).
- R6: The cycle after the fourth pop read, `ret_valid` is high for exactly one cycle. `pc_out` and `psw_out` then carry the restored values, so a push followed by a pop returns the pushed PC and status.
- R7: A software pointer write while `busy` is high is discarded, and `sp_wr_err` is high for one cycle in the following cycle. In all other cycles `sp_wr_err` is low.
- R8: Push and pop requests made while `busy` is high are ignored. When both are requested together from idle, the push is taken.
- R9: After reset, `busy`, `ram_we`, `ret_valid` and `sp_wr_err` are low and the pointer reads 0x00.
- R10: A pointer write in the same idle cycle as a request takes effect first, so the frame uses the newly written pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_req | input | 1 | Save a frame (call or interrupt entry) |
| pop_req | input | 1 | Restore a frame (return) |
| pc_in | input | PC_W | Return address to save |
| psw_in | input | 8 | Status byte to save |
| sp_wr_en | input | 1 | Software write to the stack pointer |
| sp_wr_data | input | 8 | Value for the software write |
| sp_rd | output | 8 | Current stack pointer |
| sp_wr_err | output | 1 | Pointer write refused during a frame transfer |
| busy | output | 1 | Frame transfer in progress |
| ram_addr | output | ADDR_W | Data memory address |
| ram_we | output | 1 | Data memory write enable |
| ram_wdata | output | 8 | Data memory write byte |
| ram_rdata | input | 8 | Data memory read byte (combinational read) |
| ret_valid | output | 1 | Restored context valid strobe |
| pc_out | output | PC_W | Restored return address |
| psw_out | output | 8 | Restored status byte |

## Verification
The bench aims at the pointer wrap in both directions: a push from 0x00 and a pop starting at 0xFE. A design that decrements after the store, or that fails to wrap, would write 0x00 or 0x100 and corrupt the byte below the stack. It checks every frame byte's address and content in each cycle, so a swapped order or a pointer left odd shows up as a wrong byte or as the wrong restored PC. Pointer writes and new requests are injected mid-frame. A design that accepted them would move the pointer or restart the sequence, and the final pointer would differ from sp-4. Simultaneous push and pop, and a write together with a request, check priority and ordering.

// File: rtl/stk_pkg.sv
// Shared types and constants for the call/interrupt stack controller.
// Assumes a frame of four bytes and an 8-bit stack pointer.
package stk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_POP  = 2'd2
    } stk_state_e;

    localparam int SP_W        = 8;
    localparam int FRAME_BYTES = 4;
    localparam int IDX_W       = $clog2(FRAME_BYTES);
endpackage

// File: rtl/stk_sequencer.sv
// Frame sequencer: accepts a push or pop request from idle and steps a byte
// index over FRAME_BYTES cycles. Assumes requests during a transfer are
// ignored and that push has priority over pop.
module stk_sequencer
    import stk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    output stk_state_e       state,
    output logic [IDX_W-1:0] idx,
    output logic             push_done,
    output logic             pop_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

    // State and byte index register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    idx <= '0;
                    if (push_req)     state <= ST_PUSH;
                    else if (pop_req) state <= ST_POP;
                end
                default: begin
                    if (idx == LAST_IDX) begin
                        state <= ST_IDLE;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            endcase
        end
    end

    // Completion strobes for the last byte of each frame type
    always_comb begin
        push_done = (state == ST_PUSH) && (idx == LAST_IDX);
        pop_done  = (state == ST_POP)  && (idx == LAST_IDX);
    end

    AST_TRANSFER_NOT_INTERRUPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && idx != LAST_IDX) |=> (state == $past(state))); // R8
    AST_TRANSFER_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (push_done || pop_done) |=> (state == ST_IDLE)); // R3
endmodule

// File: rtl/stk_pointer.sv
// Stack pointer register: software loads (bit 0 forced to zero) while idle,
// frame completion moves it by FRAME_BYTES. Writes during a transfer are
// refused and flagged one cycle later. Assumes wrap modulo 256.
module stk_pointer
    import stk_pkg::*;
#(
    parameter logic [SP_W-1:0] SP_RST = 8'h00
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy,
    input  logic            wr_en,
    input  logic [SP_W-1:0] wr_data,
    input  logic            push_done,
    input  logic            pop_done,
    output logic [SP_W-1:0] sp,
    output logic            wr_err
);
    localparam logic [SP_W-1:0] FRAME_STEP = SP_W'(FRAME_BYTES);

    // Pointer update and refused-write flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp     <= SP_RST;
            wr_err <= 1'b0;
        end else begin
            wr_err <= wr_en && busy;
            if (wr_en && !busy)  sp <= {wr_data[SP_W-1:1], 1'b0};
            else if (push_done)  sp <= sp - FRAME_STEP;
            else if (pop_done)   sp <= sp + FRAME_STEP;
        end
    end

    AST_SP_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        sp[0] == 1'b0); // R2
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        push_done |=> (sp == $past(sp) - FRAME_STEP)); // R3
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        pop_done |=> (sp == $past(sp) + FRAME_STEP)); // R5
    AST_BUSY_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> wr_err); // R7
    AST_ERR_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(busy && wr_en)); // R7
endmodule

// File: rtl/stk_frame.sv
// Frame datapath: latches the context on push acceptance, selects the byte
// and address for each push cycle, and collects bytes during a pop. Assumes
// a RAM with combinational read data and PC_W of at most 16.
module stk_frame
    import stk_pkg::*;
#(
    parameter int PC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_state_e       state,
    input  logic [IDX_W-1:0] idx,
    input  logic             accept_push,
    input  logic             pop_done,
    input  logic [SP_W-1:0]  sp,
    input  logic [PC_W-1:0]  pc_in,
    input  logic [7:0]       psw_in,
    input  logic [7:0]       ram_rdata,
    output logic [SP_W-1:0]  addr_lo,
    output logic             ram_we,
    output logic [7:0]       ram_wdata,
    output logic             ret_valid,
    output logic [PC_W-1:0]  pc_out,
    output logic [7:0]       psw_out
);
    localparam logic [7:0] PAD_BYTE = 8'h00;

    logic [PC_W-1:0] pc_q;
    logic [7:0]      psw_q;
    logic [15:0]     pc_ext;
    logic [7:0]      got_psw, got_pcl, got_pch;
    logic [15:0]     pc_rest;

    // Latch the context when a push is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            psw_q <= '0;
        end else if (accept_push) begin
            pc_q  <= pc_in;
            psw_q <= psw_in;
        end
    end

    assign pc_ext = 16'(pc_q);

    // Address and write byte for the current frame cycle
    always_comb begin
        ram_we    = 1'b0;
        ram_wdata = PAD_BYTE;
        addr_lo   = sp + SP_W'(idx);
        if (state == ST_PUSH) begin
            ram_we  = 1'b1;
            addr_lo = sp - SP_W'(idx) - 8'd1;
            case (idx)
                2'd0:    ram_wdata = pc_ext[15:8];
                2'd1:    ram_wdata = pc_ext[7:0];
                2'd2:    ram_wdata = psw_q;
                default: ram_wdata = PAD_BYTE;
            endcase
        end
    end

    // Collect restored bytes and raise the valid strobe after the last one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got_psw   <= '0;
            got_pcl   <= '0;
            got_pch   <= '0;
            ret_valid <= 1'b0;
        end else begin
            ret_valid <= pop_done;
            if (state == ST_POP) begin
                case (idx)
                    2'd1:    got_psw <= ram_rdata;
                    2'd2:    got_pcl <= ram_rdata;
                    2'd3:    got_pch <= ram_rdata;
                    default: ;
                endcase
            end
        end
    end

    assign pc_rest = {got_pch, got_pcl};
    assign pc_out  = pc_rest[PC_W-1:0];
    assign psw_out = got_psw;

    AST_POP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POP) |-> !ram_we); // R5
    AST_RET_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> ($past(state) == ST_POP)); // R6
    AST_RET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> !ret_valid); // R6
endmodule

// File: rtl/call_stack_ctrl.sv
// Call/interrupt stack controller top: ties the sequencer, the pointer and
// the frame datapath together and maps stack locations into bank 0.
// Assumes ADDR_W > 8 and a byte-wide RAM with combinational read.
module call_stack_ctrl
    import stk_pkg::*;
#(
    parameter int          PC_W   = 12,
    parameter int          ADDR_W = 12,
    parameter logic [7:0]  SP_RST = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [7:0]        psw_in,
    input  logic              sp_wr_en,
    input  logic [7:0]        sp_wr_data,
    output logic [7:0]        sp_rd,
    output logic              sp_wr_err,
    output logic              busy,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic              ret_valid,
    output logic [PC_W-1:0]   pc_out,
    output logic [7:0]        psw_out
);
    stk_state_e       state;
    logic [IDX_W-1:0] idx;
    logic             push_done, pop_done, accept_push;
    logic [SP_W-1:0]  sp, addr_lo;

    stk_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
        .state(state), .idx(idx), .push_done(push_done), .pop_done(pop_done)
    );

    // Transfer status and push acceptance
    always_comb begin
        busy        = (state != ST_IDLE);
        accept_push = (state == ST_IDLE) && push_req;
    end

    stk_pointer #(.SP_RST(SP_RST)) u_ptr (
        .clk(clk), .rst_n(rst_n), .busy(busy), .wr_en(sp_wr_en),
        .wr_data(sp_wr_data), .push_done(push_done), .pop_done(pop_done),
        .sp(sp), .wr_err(sp_wr_err)
    );

    stk_frame #(.PC_W(PC_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .state(state), .idx(idx),
        .accept_push(accept_push), .pop_done(pop_done), .sp(sp),
        .pc_in(pc_in), .psw_in(psw_in), .ram_rdata(ram_rdata),
        .addr_lo(addr_lo), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .ret_valid(ret_valid), .pc_out(pc_out), .psw_out(psw_out)
    );

    assign sp_rd    = sp;
    assign ram_addr = ADDR_W'(addr_lo);

    AST_RAM_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ram_addr[ADDR_W-1:8] == '0)); // R1
    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> busy); // R3
endmodule

// File: tb/call_stack_ctrl_test.sv
module call_stack_ctrl_test;
    localparam int PC_W = 12;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              push_req, pop_req, sp_wr_en;
    logic [PC_W-1:0]   pc_in;
    logic [7:0]        psw_in, sp_wr_data;
    logic [7:0]        sp_rd, ram_wdata, ram_rdata, psw_out;
    logic              sp_wr_err, busy, ram_we, ret_valid;
    logic [ADDR_W-1:0] ram_addr;
    logic [PC_W-1:0]   pc_out;
    logic [7:0]        mem [256];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    call_stack_ctrl #(.PC_W(PC_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
        .pc_in(pc_in), .psw_in(psw_in), .sp_wr_en(sp_wr_en),
        .sp_wr_data(sp_wr_data), .sp_rd(sp_rd), .sp_wr_err(sp_wr_err),
        .busy(busy), .ram_addr(ram_addr), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .ret_valid(ret_valid),
        .pc_out(pc_out), .psw_out(psw_out)
    );

    // Bank-0 RAM model: synchronous write, combinational read
    assign ram_rdata = mem[ram_addr[7:0]];
    always @(posedge clk) if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        push_req = 0; pop_req = 0; sp_wr_en = 0;
    endtask

    task automatic write_sp(input logic [7:0] v);
        @(negedge clk); sp_wr_en = 1; sp_wr_data = v;
        @(negedge clk); sp_wr_en = 0;
    endtask

    // Push one frame, checking each cycle's address and byte (R1, R3)
    task automatic push_frame(input logic [PC_W-1:0] pc, input logic [7:0] psw);
        logic [7:0] sp0, exp_b;
        @(negedge clk); sp0 = sp_rd; push_req = 1; pc_in = pc; psw_in = psw;
        @(negedge clk); push_req = 0;
        for (int k = 0; k < 4; k++) begin
            exp_b = (k == 0) ? 8'(pc >> 8) : (k == 1) ? pc[7:0] : (k == 2) ? psw : 8'h00;
            check("R3 push busy/we", {busy, ram_we}, 2'b11);
            check("R1 push addr", 32'(ram_addr), 32'(8'(sp0 - 8'(k) - 8'd1)));
            check("R3 push byte", ram_wdata, exp_b);
            @(negedge clk);
        end
        check("R3 push end busy", busy, 0);
        check("R3 push sp", sp_rd, 8'(sp0 - 8'd4));
    endtask

    // Pop one frame, checking reads and the restored context (R5, R6)
    task automatic pop_frame(input logic [PC_W-1:0] pc, input logic [7:0] psw);
        logic [7:0] sp0;
        @(negedge clk); sp0 = sp_rd; pop_req = 1;
        @(negedge clk); pop_req = 0;
        for (int k = 0; k < 4; k++) begin
            check("R5 pop busy/we", {busy, ram_we}, 2'b10);
            check("R5 pop addr", 32'(ram_addr), 32'(8'(sp0 + 8'(k))));
            check("R6 no early valid", ret_valid, 0);
            @(negedge clk);
        end
        check("R6 ret_valid", ret_valid, 1);
        check("R6 pc_out", pc_out, pc);
        check("R6 psw_out", psw_out, psw);
        check("R5 pop sp", sp_rd, 8'(sp0 + 8'd4));
        @(negedge clk);
        check("R6 ret_valid one cycle", ret_valid, 0);
    endtask

    task automatic t_reset();
        idle_inputs(); pc_in = '0; psw_in = '0; sp_wr_data = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R9 reset busy", busy, 0);
        check("R9 reset we", ram_we, 0);
        check("R9 reset valid", ret_valid, 0);
        check("R9 reset err", sp_wr_err, 0);
        check("R9 reset sp", sp_rd, 8'h00);
    endtask

    task automatic t_sp_write();
        write_sp(8'h5B);
        check("R2 sp odd write forced even", sp_rd, 8'h5A);
        write_sp(8'h80);
        check("R2 sp write", sp_rd, 8'h80);
        check("R7 no err when idle", sp_wr_err, 0);
    endtask

    task automatic t_round_trip();
        write_sp(8'h80);
        push_frame(12'hA5C, 8'h3E);
        push_frame(12'h123, 8'hC1);
        pop_frame(12'h123, 8'hC1);
        pop_frame(12'hA5C, 8'h3E);
    endtask

    task automatic t_wrap_push();
        write_sp(8'h00);
        push_frame(12'hF0F, 8'h99);
        check("R4 top byte at FF", mem[8'hFF], 8'h0F);
        check("R4 sp after wrap", sp_rd, 8'hFC);
        pop_frame(12'hF0F, 8'h99);
        check("R5 pop wraps to 00", sp_rd, 8'h00);
    endtask

    task automatic t_wrap_pop();
        mem[8'hFE] = 8'h00; mem[8'hFF] = 8'h6D;
        mem[8'h00] = 8'h34; mem[8'h01] = 8'h07;
        write_sp(8'hFE);
        pop_frame(12'h734, 8'h6D);
        check("R5 pop wrap sp", sp_rd, 8'h02);
    endtask

    task automatic t_busy_write();
        write_sp(8'h40);
        @(negedge clk); push_req = 1; pc_in = 12'h321; psw_in = 8'h11;
        @(negedge clk); push_req = 0;
        @(negedge clk); sp_wr_en = 1; sp_wr_data = 8'h10;
        @(negedge clk); sp_wr_en = 0;
        check("R7 err flagged", sp_wr_err, 1);
        check("R7 sp unchanged", sp_rd, 8'h40);
        @(negedge clk);
        check("R7 err one cycle", sp_wr_err, 0);
        @(negedge clk);
        check("R7 push completes", busy, 0);
        check("R7 sp after refused write", sp_rd, 8'h3C);
    endtask

    task automatic t_busy_requests();
        write_sp(8'h60);
        @(negedge clk); push_req = 1; pop_req = 1; pc_in = 12'h055; psw_in = 8'hAA;
        @(negedge clk);
        check("R8 push wins", ram_we, 1);
        @(negedge clk);
        check("R8 still pushing", ram_we, 1);
        @(negedge clk); push_req = 0; pop_req = 0;
        @(negedge clk);
        @(negedge clk);
        check("R8 no restart", busy, 0);
        check("R8 one frame only", sp_rd, 8'h5C);
    endtask

    task automatic t_same_cycle();
        write_sp(8'h90);
        @(negedge clk); sp_wr_en = 1; sp_wr_data = 8'h20; push_req = 1;
        pc_in = 12'h777; psw_in = 8'h01;
        @(negedge clk); sp_wr_en = 0; push_req = 0;
        check("R10 frame uses new sp", 32'(ram_addr), 32'h1F);
        repeat (4) @(negedge clk);
        check("R10 final sp", sp_rd, 8'h1C);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        t_reset();
        t_sp_write();
        t_round_trip();
        t_wrap_push();
        t_wrap_pop();
        t_busy_write();
        t_busy_requests();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule